// File: doc/BRIEF.md
# IO Virtual Address Translation Unit

This block turns IO virtual addresses issued by a device into physical addresses. A single translation window is defined by a base, a mask and an enable flag. Software sets the window, the IO page size and the location of an in-memory page directory through a small register file on a plain write/read bus. A request whose address falls in the enabled window is split into a page number and an in-page offset. The page number picks a 64-bit directory entry, which the block fetches over a memory read port when it has no cached copy. The entry then yields the physical page, or a fault when its valid flag is clear.

Recent translations are kept in a small fully associative cache with round-robin replacement. Software removes stale translations with a purge command. One 64-bit write to the purge register gives both the start of an aligned range and the log2 of its length. A new page-size setting or a new directory base drops every cached translation. While a purge walks the cache, new requests are held off, so none can hit an entry that is about to be removed.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready is high, rsp_valid and mem_rd_valid are low, and every register reads back as zero.
- R2: Registers are decoded on reg_addr: window base 0x300, window mask 0x308, purge command 0x310, page-size code 0x318 (bits 1:0), directory base 0x320. Each reads back the last value written, truncated to the address width. The purge register reads as zero.
- R3: When bit 0 of the window base register is clear, every request faults and no memory read is issued.
- R4: A request is in the window only if ((va XOR base) AND mask) is zero, where base is the window base with bit 0 cleared. A request outside the window faults without a memory read.
- R5: On a cache miss, exactly one memory read is issued, at directory base + 8 x ((va - base) >> shift). The page-size code selects the shift: 0 gives 12, 1 gives 13, 2 gives 14 and 3 gives 16.
- R6: An entry with bit 63 clear gives a fault and is not cached. An entry with bit 63 set gives a physical address built from entry bits [AW-1:shift] above va bits [shift-1:0].
- R7: A request to a page already cached returns the same physical address with no memory read.
- R8: The cache holds TLB_DEPTH (8) entries. A fill after the last cache clear goes to slots in round-robin order starting from slot 0, so the ninth distinct page evicts the first one.
- R9: A purge write carries the log2 of the range length in bits 5:0 and the range start in the bits above. Every cached page that overlaps [start, start + 2^log2) is invalidated, and the other pages stay cached.
- R10: For TLB_DEPTH cycles after a purge write, req_ready is low.
- R11: Writing the page-size code or the directory base clears the whole cache. The next request to any page then misses.
- R12: Every accepted request gets exactly one rsp_valid pulse, one cycle wide. When rsp_fault is high, rsp_pa is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for writes and reads |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on reg_addr) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | AW | IO virtual address |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_pa | output | AW | Physical address, zero on fault |
| mem_rd_valid | output | 1 | Directory entry read request pulse |
| mem_rd_addr | output | AW | Byte address of the directory entry |
| mem_rsp_valid | input | 1 | Directory entry returned |
| mem_rsp_data | input | 64 | Directory entry contents |

## Verification
A cache slot that was not cleared by a purge or a configuration write is not visible at once. It shows up only when a later request to that page returns with no memory read, or returns an old physical address, so the bench counts memory reads for every request. A wrong replacement pointer only shows once nine distinct pages have been filled, when the miss lands on the wrong page. A wrong directory index is seen at once, on the mem_rd_addr of the first miss. A wrong offset width is seen in rsp_pa one cycle after the entry returns.

// File: rtl/iova_pkg.sv
package iova_pkg;

   localparam logic [11:0] OFS_WBASE = 12'h300;
   localparam logic [11:0] OFS_WMASK = 12'h308;
   localparam logic [11:0] OFS_PURGE = 12'h310;
   localparam logic [11:0] OFS_PGCFG = 12'h318;
   localparam logic [11:0] OFS_DBASE = 12'h320;

   typedef enum logic [1:0] {
      XS_IDLE,
      XS_LOOK,
      XS_FETCH,
      XS_WAIT
   } xs_t;

   // non-linear page-size code: 0..3 -> 12,13,14,16
   function automatic logic [4:0] pgcode_to_shift(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd12;
         2'd1:    return 5'd13;
         2'd2:    return 5'd14;
         default: return 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/iova_regs.sv
module iova_regs
   import iova_pkg::*;
#(
   parameter int AW = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [11:0]   addr,
   input  logic [63:0]   wdata,
   output logic [63:0]   rdata,
   output logic          win_en,
   output logic [AW-1:0] win_base,
   output logic [AW-1:0] win_mask,
   output logic [4:0]    pg_shift,
   output logic [AW-1:0] dir_base,
   output logic          purge_go,
   output logic [AW-1:0] purge_base,
   output logic [5:0]    purge_log,
   output logic          cfg_flush
);

   localparam int PADW = 64 - AW;

   logic [AW-1:0] base_q, mask_q, dir_q;
   logic [1:0]    code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         dir_q  <= '0;
         code_q <= '0;
      end else if (wr_en) begin
         case (addr)
            OFS_WBASE: base_q <= wdata[AW-1:0];
            OFS_WMASK: mask_q <= wdata[AW-1:0];
            OFS_PGCFG: code_q <= wdata[1:0];
            OFS_DBASE: dir_q  <= wdata[AW-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         OFS_WBASE: rdata = {{PADW{1'b0}}, base_q};
         OFS_WMASK: rdata = {{PADW{1'b0}}, mask_q};
         OFS_PGCFG: rdata = {62'd0, code_q};
         OFS_DBASE: rdata = {{PADW{1'b0}}, dir_q};
         default:   rdata = '0;
      endcase
   end

   assign win_en     = base_q[0];
   assign win_base   = {base_q[AW-1:1], 1'b0};
   assign win_mask   = mask_q;
   assign pg_shift   = pgcode_to_shift(code_q);
   assign dir_base   = dir_q;
   assign purge_go   = wr_en && (addr == OFS_PURGE);
   assign purge_base = {wdata[AW-1:6], 6'd0};
   assign purge_log  = wdata[5:0];
   assign cfg_flush  = wr_en && ((addr == OFS_PGCFG) || (addr == OFS_DBASE));

   logic unused_hi;
   assign unused_hi = ^wdata[63:AW];

   // R2: base readback keeps the enable flag that drives win_en
   a_r2_enable_tracks_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_WBASE) |=> (win_en == $past(wdata[0])));

endmodule

// File: rtl/iova_tlb.sv
module iova_tlb #(
   parameter int AW         = 40,
   parameter int DEPTH      = 8,
   parameter bit PURGE_WALK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [4:0]    shift,
   input  logic [AW-1:0] lk_vpn,
   output logic          lk_hit,
   output logic [AW-1:0] lk_page,
   input  logic          fill_en,
   input  logic [AW-1:0] fill_vpn,
   input  logic [AW-1:0] fill_page,
   input  logic          purge_go,
   input  logic [AW-1:0] purge_base,
   input  logic [5:0]    purge_log,
   output logic          purge_busy
);

   localparam int IW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("iova_tlb: DEPTH must be a power of two, at least 2");

   logic [DEPTH-1:0] vld_q, match, kill;
   logic [AW-1:0]    tag_arr [DEPTH];
   logic [AW-1:0]    page_arr[DEPTH];
   logic [IW-1:0]    rr_q;
   logic [AW-1:0]    pbase_q, keep_q, keep_d;
   logic [5:0]       lim;
   logic             busy_q;

   // keep bits at and above max(log2 range, page shift)
   always_comb begin
      lim = (purge_log > {1'b0, shift}) ? purge_log : {1'b0, shift};
      if (int'(lim) >= AW) keep_d = '0;
      else                 keep_d = ~((AW'(1) << lim) - AW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pbase_q <= '0;
         keep_q  <= '0;
      end else if (purge_go) begin
         pbase_q <= purge_base;
         keep_q  <= keep_d;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_look
      assign match[i] = vld_q[i] && (tag_arr[i] == lk_vpn);
   end

   always_comb begin
      lk_page = '0;
      for (int i = 0; i < DEPTH; i++)
         if (match[i]) lk_page = lk_page | page_arr[i];
   end
   assign lk_hit = |match;

   if (PURGE_WALK) begin : g_walk
      logic [IW-1:0] idx_q;
      logic          hit_idx;
      assign hit_idx = (((tag_arr[idx_q] << shift) ^ pbase_q) & keep_q) == '0;
      always_comb begin
         kill = '0;
         if (busy_q && hit_idx) kill[idx_q] = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else if (purge_go) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (busy_q) begin
            if (idx_q == IW'(DEPTH - 1)) busy_q <= 1'b0;
            idx_q <= idx_q + IW'(1);
         end
      end
   end else begin : g_par
      for (genvar i = 0; i < DEPTH; i++) begin : g_kill
         assign kill[i] = busy_q &&
            ((((tag_arr[i] << shift) ^ pbase_q) & keep_q) == '0);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= purge_go;
      end
   end

   assign purge_busy = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else if (flush) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++)
            if (kill[i]) vld_q[i] <= 1'b0;
         if (fill_en) begin
            vld_q[rr_q] <= 1'b1;
            rr_q        <= rr_q + IW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         tag_arr[rr_q]  <= fill_vpn;
         page_arr[rr_q] <= fill_page;
      end
   end

   // R7: fills only happen on a miss, so a page never sits in two slots
   a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R11: a configuration write leaves no valid slot behind
   a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
   import iova_pkg::*;
#(
   parameter int AW         = 40,
   parameter int TLB_DEPTH  = 8,
   parameter bit PURGE_WALK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [11:0]   reg_addr,
   input  logic [63:0]   reg_wdata,
   output logic [63:0]   reg_rdata,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_va,
   output logic          rsp_valid,
   output logic          rsp_fault,
   output logic [AW-1:0] rsp_pa,
   output logic          mem_rd_valid,
   output logic [AW-1:0] mem_rd_addr,
   input  logic          mem_rsp_valid,
   input  logic [63:0]   mem_rsp_data
);

   if (AW < 32 || AW > 63)
      $error("iova_xlate: AW must lie in 32..63 so bit 63 stays the valid flag");

   logic          win_en, purge_go, cfg_flush, purge_busy, lk_hit, fill_en;
   logic [AW-1:0] win_base, win_mask, dir_base, purge_base, lk_page;
   logic [4:0]    pg_shift;
   logic [5:0]    purge_log;

   iova_regs #(.AW(AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .win_en     (win_en),
      .win_base   (win_base),
      .win_mask   (win_mask),
      .pg_shift   (pg_shift),
      .dir_base   (dir_base),
      .purge_go   (purge_go),
      .purge_base (purge_base),
      .purge_log  (purge_log),
      .cfg_flush  (cfg_flush)
   );

   xs_t           state_q;
   logic [AW-1:0] va_q, off_mask, vpn, dir_idx, ent_page;
   logic          in_win;
   logic          rsp_v_q, rsp_f_q;
   logic [AW-1:0] rsp_pa_q;

   assign off_mask = (AW'(1) << pg_shift) - AW'(1);
   assign in_win   = win_en && (((va_q ^ win_base) & win_mask) == '0);
   assign vpn      = va_q >> pg_shift;
   assign dir_idx  = (va_q - win_base) >> pg_shift;
   assign ent_page = mem_rsp_data[AW-1:0] & ~off_mask;
   assign fill_en  = (state_q == XS_WAIT) && mem_rsp_valid && mem_rsp_data[63];

   iova_tlb #(.AW(AW), .DEPTH(TLB_DEPTH), .PURGE_WALK(PURGE_WALK)) u_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (cfg_flush),
      .shift      (pg_shift),
      .lk_vpn     (vpn),
      .lk_hit     (lk_hit),
      .lk_page    (lk_page),
      .fill_en    (fill_en),
      .fill_vpn   (vpn),
      .fill_page  (ent_page),
      .purge_go   (purge_go),
      .purge_base (purge_base),
      .purge_log  (purge_log),
      .purge_busy (purge_busy)
   );

   assign req_ready    = (state_q == XS_IDLE) && !purge_busy;
   assign mem_rd_valid = (state_q == XS_FETCH);
   assign mem_rd_addr  = dir_base + (dir_idx << 3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= XS_IDLE;
         va_q     <= '0;
         rsp_v_q  <= 1'b0;
         rsp_f_q  <= 1'b0;
         rsp_pa_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         case (state_q)
            XS_IDLE: if (req_valid && req_ready) begin
               va_q    <= req_va;
               state_q <= XS_LOOK;
            end
            XS_LOOK: begin
               if (!in_win) begin
                  rsp_v_q  <= 1'b1;
                  rsp_f_q  <= 1'b1;
                  rsp_pa_q <= '0;
                  state_q  <= XS_IDLE;
               end else if (lk_hit) begin
                  rsp_v_q  <= 1'b1;
                  rsp_f_q  <= 1'b0;
                  rsp_pa_q <= lk_page | (va_q & off_mask);
                  state_q  <= XS_IDLE;
               end else begin
                  state_q <= XS_FETCH;
               end
            end
            XS_FETCH: state_q <= XS_WAIT;
            XS_WAIT: if (mem_rsp_valid) begin
               rsp_v_q  <= 1'b1;
               rsp_f_q  <= !mem_rsp_data[63];
               rsp_pa_q <= mem_rsp_data[63] ? (ent_page | (va_q & off_mask)) : '0;
               state_q  <= XS_IDLE;
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_fault = rsp_f_q;
   assign rsp_pa    = rsp_pa_q;

   logic unused_ent;
   assign unused_ent = ^mem_rsp_data[62:AW];

   // R12: results are single-cycle pulses
   a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R12: a fault never carries an address
   a_r12_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

   // R3: no directory fetch while the window is switched off
   a_r3_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> win_en);

   // R5: one read per miss
   a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);

   // R10: no lookup starts from a request taken during a purge walk
   a_r10_no_accept_in_purge: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XS_LOOK && $past(state_q) == XS_IDLE) |-> !$past(purge_busy));

endmodule

// File: tb/iova_xlate_bench.sv
`timescale 1ns/1ps
module iova_xlate_bench;
   import iova_pkg::*;

   localparam int AW    = 40;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_va = '0;
   logic          rsp_valid, rsp_fault;
   logic [AW-1:0] rsp_pa;
   logic          mem_rd_valid;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [63:0]   mem_rsp_data = '0;

   always #2 clk = ~clk;

   iova_xlate #(.AW(AW), .TLB_DEPTH(DEPTH)) u_iova_xlate (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   int n_chk = 0, n_fail = 0, n_reads = 0, n_rsp = 0, n_req = 0;
   logic [AW-1:0] last_rd_addr = '0;
   logic [AW-1:0] b_base = 40'h40_0000_0000 >> 8;
   logic [AW-1:0] b_dir  = 40'h10_0000;
   int            b_sh   = 12;

   typedef struct {
      logic          fault;
      logic [AW-1:0] pa;
      string         req;
   } exp_t;
   exp_t sbq[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // directory model: index 0xFF (entry address bits 10:3) holds an invalid entry
   function automatic logic [63:0] ent(input logic [AW-1:0] a);
      if (a[10:3] == 8'hFF) return 64'h0000_000A_BCD0_0000;
      return {1'b1, 27'd0, a[22:3] + 20'h55, 16'h0};
   endfunction

   int            lat_cnt = 0;
   logic [AW-1:0] lat_addr = '0;
   always @(negedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (lat_cnt != 0) begin
         lat_cnt <= lat_cnt - 1;
         if (lat_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= ent(lat_addr);
         end
      end
      if (rst_n && mem_rd_valid) begin
         lat_cnt      <= 2;
         lat_addr     <= mem_rd_addr;
         last_rd_addr <= mem_rd_addr;
         n_reads      <= n_reads + 1;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && rsp_valid) begin
         n_rsp++;
         if (sbq.size() == 0) begin
            chk(1'b0, "R12 unexpected response", {63'd0, rsp_valid}, 64'd0);
         end else begin
            e = sbq.pop_front();
            chk(rsp_fault == e.fault, {e.req, " fault"}, {63'd0, rsp_fault}, {63'd0, e.fault});
            chk(rsp_pa == e.pa, {e.req, " pa"}, {24'd0, rsp_pa}, {24'd0, e.pa});
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic xlate(input logic [AW-1:0] va, input bit efault, input int ereads, input string req);
      exp_t          e;
      int            r0;
      logic [AW-1:0] idx, ea, om;
      idx = (va - b_base) >> b_sh;
      ea  = b_dir + (idx << 3);
      om  = (AW'(1) << b_sh) - AW'(1);
      e.fault = efault;
      e.pa    = efault ? '0 : ((ent(ea)[AW-1:0] & ~om) | (va & om));
      e.req   = req;
      r0 = n_reads;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      sbq.push_back(e);
      req_valid = 1'b1; req_va = va; n_req++;
      @(negedge clk);
      req_valid = 1'b0;
      while (sbq.size() != 0) @(negedge clk);
      chk(n_reads - r0 == ereads, {req, " read count"}, 64'(n_reads - r0), 64'(ereads));
      if (ereads == 1)
         chk(last_rd_addr == ea, "R5 entry address", {24'd0, last_rd_addr}, {24'd0, ea});
   endtask

   function automatic logic [AW-1:0] pg(input int k);
      return 40'h00_4000_0000 + AW'(k << 12) + 40'h10;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [63:0] d;
      int          n;
      b_base = 40'h00_4000_0000;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready", {63'd0, req_ready}, 64'd1);
      chk(rsp_valid == 1'b0, "R1 rsp", {63'd0, rsp_valid}, 64'd0);
      chk(mem_rd_valid == 1'b0, "R1 mem", {63'd0, mem_rd_valid}, 64'd0);
      rd(OFS_WBASE, d); chk(d == 64'd0, "R1 base reg", d, 64'd0);
      rd(OFS_PGCFG, d); chk(d == 64'd0, "R1 pgcfg reg", d, 64'd0);

      // R3 window disabled
      wr(OFS_WBASE, 64'h4000_0000);
      wr(OFS_WMASK, 64'hFF_C000_0000);
      wr(OFS_DBASE, 64'h10_0000);
      xlate(40'h00_4000_1000, 1'b1, 0, "R3 disabled");

      // R2 register map
      wr(OFS_WBASE, 64'h4000_0001);
      rd(OFS_WBASE, d); chk(d == 64'h4000_0001, "R2 base", d, 64'h4000_0001);
      rd(OFS_WMASK, d); chk(d == 64'hFF_C000_0000, "R2 mask", d, 64'hFF_C000_0000);
      rd(OFS_DBASE, d); chk(d == 64'h10_0000, "R2 dir", d, 64'h10_0000);
      rd(OFS_PURGE, d); chk(d == 64'd0, "R2 purge reads 0", d, 64'd0);

      // R5/R6 miss then R7 hit
      xlate(40'h00_4000_1234, 1'b0, 1, "R6 miss pa");
      xlate(40'h00_4000_1ABC, 1'b0, 0, "R7 hit");

      // R4 outside window
      xlate(40'h00_8000_0000, 1'b1, 0, "R4 above");
      xlate(40'h00_3FFF_F000, 1'b1, 0, "R4 below");

      // R6 invalid entry, not cached
      xlate(40'h00_400F_F000, 1'b1, 1, "R6 invalid");
      xlate(40'h00_400F_F008, 1'b1, 1, "R6 invalid again");

      // R5 page-size codes; R11 flush on code write
      wr(OFS_PGCFG, 64'd3); b_sh = 16;
      rd(OFS_PGCFG, d); chk(d == 64'd3, "R2 pgcfg", d, 64'd3);
      xlate(40'h00_4000_1234, 1'b0, 1, "R11 R5 shift16");
      wr(OFS_PGCFG, 64'd2); b_sh = 14;
      xlate(40'h00_4000_C123, 1'b0, 1, "R5 shift14");
      wr(OFS_PGCFG, 64'd1); b_sh = 13;
      xlate(40'h00_4000_6001, 1'b0, 1, "R5 shift13");
      wr(OFS_PGCFG, 64'd0); b_sh = 12;

      // R8 round robin
      for (int k = 0; k < 8; k++) xlate(pg(k), 1'b0, 1, "R8 fill");
      for (int k = 0; k < 8; k++) xlate(pg(k), 1'b0, 0, "R8 all cached");
      xlate(pg(8), 1'b0, 1, "R8 ninth");
      xlate(pg(1), 1'b0, 0, "R8 second kept");
      xlate(pg(0), 1'b0, 1, "R8 first evicted");

      // R11 directory base write flushes
      wr(OFS_DBASE, 64'h10_0000);
      xlate(pg(2), 1'b0, 1, "R11 dir flush");

      // R9/R10 purge
      wr(OFS_PGCFG, 64'd0);
      for (int k = 0; k < 8; k++) xlate(pg(k), 1'b0, 1, "R9 fill");
      wr(OFS_PURGE, 64'h4000_200D);
      n = 0;
      while (!req_ready) begin n++; @(negedge clk); end
      chk(n == DEPTH, "R10 purge stall", 64'(n), 64'(DEPTH));
      xlate(pg(1), 1'b0, 0, "R9 below range kept");
      xlate(pg(4), 1'b0, 0, "R9 above range kept");
      xlate(pg(2), 1'b0, 1, "R9 purged low");
      xlate(pg(3), 1'b0, 1, "R9 purged high");
      wr(OFS_PURGE, 64'h4000_5046);
      xlate(pg(6), 1'b0, 0, "R9 small range neighbour kept");
      xlate(pg(5), 1'b0, 1, "R9 small range page purged");

      repeat (4) @(negedge clk);
      chk(n_rsp == n_req, "R12 one response per request", 64'(n_rsp), 64'(n_req));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule